// File: doc/BRIEF.md
# Programmable Single-Bit Sorting Network Pipeline

This block evaluates a candidate sorting network on vectors of one-bit items. The network is a chain of registered stages; each stage can hold one compare-exchange between two lines of a 16-line vector, or pass the vector through unchanged. Because every item is a single bit, a compare-exchange is an AND/OR pair. The AND goes to the lower-numbered line and the OR to the higher one, so zeros collect on the low indices. A network for k items (k up to 16) uses the low k lines.

Before a run, a host loads the candidate network one stage at a time through a write port. The port takes a stage number, two line numbers and an enable flag. A run begins with a clear pulse that empties every stage. After that, one vector may enter on every clock, tagged by a valid bit that travels with it. Each vector comes out a fixed number of clocks later. Stages left unprogrammed act as wires with a register, so a short network gives the same latency as a full one.

Top module: `bitsort_pipe`

## Requirements
- R1: An enabled stage with lines lo < hi drives lo with the AND and hi with the OR of its two incoming bits, so a 1 never sits on a lower line than a 0 of that pair. A correct network (for example the five-step 4-item sorter) therefore delivers all zeros on the low lines.
- R2: Every line not named by a stage's operation, and every line of a disabled stage, leaves the stage with the bit it entered with.
- R3: A vector presented on in_vec before clock edge t appears on out_vec after edge t+79, so the latency is 80 cycles whatever the number of enabled stages. in_valid travels the same path to out_valid, and one vector may enter on every cycle.
- R4: A run_start pulse sampled at an edge sets every stage register, data and valid, to zero at that edge. Inputs presented in that cycle are dropped.
- R5: A configuration write stores stage cfg_stage with the two line numbers in either order. The block orders them itself, so (5,2) behaves exactly like (2,5).
- R6: A write is ignored when busy is high, when in_valid is high in the same cycle, or when cfg_stage is 80 or more. The stored network is then unchanged.
- R7: An operation whose two line numbers are equal, or which repeats the enabled operation of the stage just before it, acts as a pass-through stage. Data results match the network with that stage removed.
- R8: After reset every stage is disabled, out_vec is zero, and out_valid and busy are low.
- R9: busy is high exactly when at least one stage register holds a valid vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start | input | 1 | Synchronous clear of all stage registers at the start of a run |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stage | input | 7 | Stage number to write |
| cfg_line_a | input | 4 | First line of the compare-exchange |
| cfg_line_b | input | 4 | Second line of the compare-exchange |
| cfg_active | input | 1 | Stage performs its compare-exchange when set |
| in_valid | input | 1 | Marks in_vec as a real vector |
| in_vec | input | 16 | Incoming bit vector |
| out_valid | output | 1 | Valid tag leaving the last stage |
| out_vec | output | 16 | Vector leaving the last stage |
| busy | output | 1 | Some stage holds a valid vector |

## Verification
The bench sweeps every low-nibble pattern through a known 4-item sorter. If AND and OR were swapped onto the wrong line, the zeros would gather on the high lines. It loads networks with line numbers in reversed order, repeats and equal pairs. A design that skipped the ordering step would put the OR on the lower line, and the repeated and equal pairs must leave the data as a plain pass-through would. It also tries writes while vectors are in flight, while a vector enters an empty pipe, and to stage numbers past the end. A design that took any of them would corrupt later results, which the bench compares cycle by cycle against its own model of the network. A clear pulse is issued while data is still in flight. A design with a leaky clear, or with an off-by-one latency, would show stale vectors or a misaligned stream.

// File: rtl/bitsort_pkg.sv
package bitsort_pkg;
  localparam int unsigned DEF_LINES  = 16;
  localparam int unsigned DEF_STAGES = 80;

  typedef enum logic {
    OP_PASS = 1'b0,
    OP_CMPX = 1'b1
  } stage_op_e;
endpackage

// File: rtl/bitsort_cfg_store.sv
module bitsort_cfg_store #(
  parameter int unsigned NUM_LINES  = 16,
  parameter int unsigned NUM_STAGES = 80,
  localparam int unsigned IDX_W  = $clog2(NUM_LINES),
  localparam int unsigned SIDX_W = $clog2(NUM_STAGES)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic                                  hold,
  input  logic [SIDX_W-1:0]                     wr_stage,
  input  logic [IDX_W-1:0]                      wr_a,
  input  logic [IDX_W-1:0]                      wr_b,
  input  logic                                  wr_act,
  output logic [NUM_STAGES-1:0]                 op_en,
  output logic [NUM_STAGES-1:0][IDX_W-1:0]      op_lo,
  output logic [NUM_STAGES-1:0][IDX_W-1:0]      op_hi
);
  logic [NUM_STAGES-1:0]            act_q, act_d;
  logic [NUM_STAGES-1:0][IDX_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic                             wr_ok;
  logic [IDX_W-1:0]                 n_lo, n_hi;

  assign wr_ok = wr_en && !hold && (int'(wr_stage) < NUM_STAGES);
  assign n_lo  = (wr_a <= wr_b) ? wr_a : wr_b;
  assign n_hi  = (wr_a <= wr_b) ? wr_b : wr_a;

  always_comb begin
    act_d = act_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    if (wr_ok) begin
      act_d[wr_stage] = wr_act;
      lo_d[wr_stage]  = n_lo;
      hi_d[wr_stage]  = n_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (wr_ok) begin
      act_q <= act_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_eff
    logic degen;
    if (s == 0) begin : g_first
      assign degen = (lo_q[s] == hi_q[s]);
    end else begin : g_rest
      assign degen = (lo_q[s] == hi_q[s]) ||
                     (act_q[s-1] && lo_q[s-1] == lo_q[s] && hi_q[s-1] == hi_q[s]);
    end
    assign op_en[s] = act_q[s] && !degen;
    assign op_lo[s] = lo_q[s];
    assign op_hi[s] = hi_q[s];

    AST_CFG_NORM: assert property (@(posedge clk) disable iff (!rst_n)
      lo_q[s] <= hi_q[s]) else $error("normalisation broken"); // R5
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold) |=> ($stable(act_q) && $stable(lo_q) && $stable(hi_q)))
    else $error("write taken while busy"); // R6
endmodule

// File: rtl/bitsort_stage.sv
module bitsort_stage
  import bitsort_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 op_en,
  input  logic [IDX_W-1:0]     lo,
  input  logic [IDX_W-1:0]     hi,
  input  logic [NUM_LINES-1:0] d_in,
  input  logic                 v_in,
  output logic [NUM_LINES-1:0] d_q,
  output logic                 v_q
);
  stage_op_e              kind;
  logic [NUM_LINES-1:0]   d_nxt;
  logic                   v_nxt;
  logic [NUM_LINES-1:0]   lo_mask, hi_mask;

  assign kind    = op_en ? OP_CMPX : OP_PASS;
  assign lo_mask = NUM_LINES'(1) << lo;
  assign hi_mask = NUM_LINES'(1) << hi;

  always_comb begin
    d_nxt = d_in;
    v_nxt = v_in;
    case (kind)
      OP_CMPX: begin
        d_nxt[lo] = d_in[lo] & d_in[hi];
        d_nxt[hi] = d_in[lo] | d_in[hi];
      end
      default: d_nxt = d_in;
    endcase
    if (clr) begin
      d_nxt = '0;
      v_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      v_q <= 1'b0;
    end else begin
      d_q <= d_nxt;
      v_q <= v_nxt;
    end
  end

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op_en) |=> !((|(d_q & $past(lo_mask))) && !(|(d_q & $past(hi_mask)))))
    else $error("pair left unordered"); // R1
  AST_ONES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($countones(d_q) == $countones($past(d_in))))
    else $error("ones count changed"); // R1
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !op_en) |=> (d_q == $past(d_in)))
    else $error("disabled stage altered data"); // R2
  AST_VALID_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (v_q == $past(v_in)))
    else $error("valid tag lost"); // R3
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (d_q == '0 && !v_q))
    else $error("clear incomplete"); // R4
endmodule

// File: rtl/bitsort_pipe.sv
module bitsort_pipe
  import bitsort_pkg::*;
#(
  parameter int unsigned NUM_LINES  = DEF_LINES,
  parameter int unsigned NUM_STAGES = DEF_STAGES,
  localparam int unsigned IDX_W  = $clog2(NUM_LINES),
  localparam int unsigned SIDX_W = $clog2(NUM_STAGES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_start,
  input  logic                 cfg_we,
  input  logic [SIDX_W-1:0]    cfg_stage,
  input  logic [IDX_W-1:0]     cfg_line_a,
  input  logic [IDX_W-1:0]     cfg_line_b,
  input  logic                 cfg_active,
  input  logic                 in_valid,
  input  logic [NUM_LINES-1:0] in_vec,
  output logic                 out_valid,
  output logic [NUM_LINES-1:0] out_vec,
  output logic                 busy
);
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic [NUM_STAGES-1:0]            op_en;
  logic [NUM_STAGES-1:0][IDX_W-1:0] op_lo, op_hi;
  logic [NUM_STAGES:0][NUM_LINES-1:0] d_chain;
  logic [NUM_STAGES:0]              v_chain;

  bitsort_cfg_store #(
    .NUM_LINES (NUM_LINES),
    .NUM_STAGES(NUM_STAGES)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (cfg_we),
    .hold    (busy || in_valid),
    .wr_stage(cfg_stage),
    .wr_a    (cfg_line_a),
    .wr_b    (cfg_line_b),
    .wr_act  (cfg_active),
    .op_en   (op_en),
    .op_lo   (op_lo),
    .op_hi   (op_hi)
  );

  assign d_chain[0] = in_vec;
  assign v_chain[0] = in_valid;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    bitsort_stage #(.NUM_LINES(NUM_LINES)) u_stage (
      .clk  (clk),
      .rst_n(rst_n_i),
      .clr  (run_start),
      .op_en(op_en[s]),
      .lo   (op_lo[s]),
      .hi   (op_hi[s]),
      .d_in (d_chain[s]),
      .v_in (v_chain[s]),
      .d_q  (d_chain[s+1]),
      .v_q  (v_chain[s+1])
    );
  end

  assign out_vec   = d_chain[NUM_STAGES];
  assign out_valid = v_chain[NUM_STAGES];
  assign busy      = |v_chain[NUM_STAGES:1];

  AST_OUT_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_valid |-> busy) else $error("valid output while idle"); // R9
  AST_IDLE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_i)
    run_start |=> !busy) else $error("busy after clear"); // R4
endmodule

// File: tb/tb_bitsort_pipe.sv
`timescale 1ns/1ps
module tb_bitsort_pipe;
  localparam int LINES = 16;
  localparam int STAGES = 80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_start, cfg_we, cfg_active, in_valid;
  logic [6:0]  cfg_stage;
  logic [3:0]  cfg_line_a, cfg_line_b;
  logic [15:0] in_vec;
  logic        out_valid, busy;
  logic [15:0] out_vec;

  always #10 clk = ~clk;

  bitsort_pipe dut (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .cfg_we(cfg_we),
    .cfg_stage(cfg_stage), .cfg_line_a(cfg_line_a), .cfg_line_b(cfg_line_b),
    .cfg_active(cfg_active), .in_valid(in_valid), .in_vec(in_vec),
    .out_valid(out_valid), .out_vec(out_vec), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit       m_act [STAGES];
  bit [3:0] m_a   [STAGES];
  bit [3:0] m_b   [STAGES];

  logic [15:0] hist_d [1024];
  bit          hist_v [1024];

  function automatic logic [15:0] model(input logic [15:0] v);
    logic [15:0] r = v;
    for (int s = 0; s < STAGES; s++) begin
      if (m_act[s]) begin
        int lo = (m_a[s] < m_b[s]) ? m_a[s] : m_b[s];
        int hi = (m_a[s] < m_b[s]) ? m_b[s] : m_a[s];
        logic x = r[lo];
        logic y = r[hi];
        r[lo] = x & y;
        r[hi] = x | y;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic clear_pipe();
    @(negedge clk);
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
  endtask

  task automatic write_cfg(input int st, input int a, input int b, input bit act, input bit expect_take);
    cfg_we = 1'b1;
    cfg_stage = 7'(st);
    cfg_line_a = 4'(a);
    cfg_line_b = 4'(b);
    cfg_active = act;
    @(negedge clk);
    cfg_we = 1'b0;
    if (expect_take && st < STAGES) begin
      m_act[st] = act; m_a[st] = 4'(a); m_b[st] = 4'(b);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < STAGES; s++) begin
      m_act[s] = 0; m_a[s] = 0; m_b[s] = 0;
    end
  endtask

  // mode 0: random vectors; mode 1: low nibble sweep with sorted check
  task automatic run_phase(input int n, input int run_len, input int mode, input int gap_pct);
    clear_pipe();
    for (int c = 0; c < run_len; c++) begin
      logic [15:0] ed;
      bit ev;
      int inflight = 0;
      ed = (c >= STAGES) ? hist_d[c-STAGES] : 16'h0;
      ev = (c >= STAGES) ? hist_v[c-STAGES] : 1'b0;
      check("R3 data", out_vec, ed);
      check("R3 valid", {15'd0, out_valid}, {15'd0, ev});
      for (int k = c - STAGES; k < c; k++)
        if (k >= 0 && hist_v[k]) inflight++;
      check("R9 busy", {15'd0, busy}, {15'd0, (inflight != 0)});
      if (mode == 1 && ev) begin
        int ones = $countones(ed[3:0]);
        check("R1 sorted nibble", {12'd0, out_vec[3:0]}, 16'(((1 << ones) - 1) << (4 - ones)));
      end
      if (c < n) begin
        logic [15:0] v = 16'($urandom());
        if (mode == 1) v[3:0] = 4'(c);
        in_vec = v;
        in_valid = (c == 0 || mode == 1) ? 1'b1 : (($urandom() % 100) >= gap_pct);
        hist_d[c] = model(v);
        hist_v[c] = in_valid;
        // R6: writes during traffic are ignored
        if (c == 0 || c == n / 2) begin
          cfg_we = 1'b1; cfg_stage = 7'(c % STAGES);
          cfg_line_a = 4'($urandom()); cfg_line_b = 4'($urandom()); cfg_active = 1'b1;
        end else cfg_we = 1'b0;
      end else begin
        in_valid = 1'b0;
        in_vec = 16'($urandom());
        cfg_we = 1'b0;
        hist_d[c] = model(in_vec);
        hist_v[c] = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run_start = 1'b0; cfg_we = 1'b0; cfg_active = 1'b0;
    cfg_stage = '0; cfg_line_a = '0; cfg_line_b = '0; in_valid = 1'b0; in_vec = '0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 out_vec", out_vec, 16'h0);
    check("R8 out_valid", {15'd0, out_valid}, 16'h0);
    check("R8 busy", {15'd0, busy}, 16'h0);

    // R2/R3: unconfigured pipe is a pure delay line
    run_phase(120, 240, 0, 30);

    // R1: 4-item sorter on lines 0..3, R5 with some reversed pairs
    clear_pipe();
    clear_model();
    write_cfg(0, 1, 0, 1, 1);
    write_cfg(1, 2, 3, 1, 1);
    write_cfg(2, 2, 0, 1, 1);
    write_cfg(3, 1, 3, 1, 1);
    write_cfg(4, 2, 1, 1, 1);
    run_phase(64, 160, 1, 0);

    // R5/R7: reversed pair, repeat and equal-line stages
    clear_pipe();
    clear_model();
    write_cfg(0, 5, 2, 1, 1);
    write_cfg(1, 2, 5, 1, 1);
    write_cfg(2, 7, 7, 1, 1);
    @(negedge clk);
    in_valid = 1'b1; in_vec = 16'h0084;
    @(negedge clk);
    in_valid = 1'b0; in_vec = 16'h0000;
    repeat (STAGES - 1) @(negedge clk);
    check("R5 R7 reversed and degenerate", out_vec, 16'h00A0);
    check("R3 valid at 80", {15'd0, out_valid}, 16'h1);

    // R6: out-of-range and in_valid-high writes ignored
    clear_pipe();
    write_cfg(100, 0, 15, 1, 0);
    @(negedge clk);
    in_valid = 1'b1; in_vec = 16'h0001;
    write_cfg(3, 0, 15, 1, 0);
    in_valid = 1'b0;
    repeat (STAGES - 1) @(negedge clk);
    check("R6 ignored writes", out_vec, 16'h0001);

    // random networks, including duplicates and equal lines (R1 R2 R5 R7)
    for (int rnd = 0; rnd < 4; rnd++) begin
      clear_pipe();
      clear_model();
      for (int s = 0; s < STAGES; s++) begin
        int a = $urandom() % 16;
        int b = ($urandom() % 8 == 0) ? a : ($urandom() % 16);
        bit act = ($urandom() % 4) != 0;
        if (s > 0 && $urandom() % 8 == 0) begin a = m_b[s-1]; b = m_a[s-1]; act = m_act[s-1]; end
        write_cfg(s, a, b, act, 1);
      end
      // R4: clear while data in flight (run ends early, next phase clears)
      run_phase(200, 200 + (rnd * 40), 0, 20 * rnd);
    end
    clear_pipe();
    @(negedge clk);
    check("R4 cleared output", out_vec, 16'h0);
    check("R4 cleared busy", {15'd0, busy}, 16'h0);

    done = 1;
    finish_run();
  end
endmodule